// File: doc/BRIEF.md
# One-Hot Selected Integer ALU

This block is the arithmetic and logic stage of a small single-cycle integer core. It has no clock and no state: two 32-bit source values and a 12-bit one-hot operation vector go in, and one 32-bit result comes out in the same cycle. The decoder in front of it sets exactly one select bit per instruction. It also routes the operands, so the two sources arrive already chosen.

The unit supports the following operations:

- wrapping add and subtract
- signed and unsigned set-on-less-than
- four bitwise operations
- three shifts
- an upper-half immediate placement

For the shifts, the distance comes from the low bits of the first source and the value being shifted is the second source. Because of this, a decoder can put an instruction's shift field on source A without moving the register value off source B.

Top module: `alu_onehot`

## Requirements
- R1: With select bit 11 set, the result is A plus B modulo 2^32 (for example 1 + 19 = 0x14, and 0xFFFFFFFF + 1 = 0).
- R2: With select bit 10 set, the result is A minus B modulo 2^32 (0 - 1 = 0xFFFFFFFF).
- R3: With select bit 9 set, the result is 1 when A is less than B as two's-complement values and 0 otherwise. It is zero-extended to 32 bits (0xFFFFFFE2 vs 0xFFFFFFF3 gives 1).
- R4: With select bit 8 set, the result is 1 when A is less than B as unsigned values and 0 otherwise. It is zero-extended.
- R5: Select bits 7, 6, 5 and 4 give A AND B, NOR(A,B), A OR B and A XOR B respectively (NOR of 0xD and 0x10 is 0xFFFFFFE2).
- R6: With select bit 3 set, the result is B shifted left by A[4:0] with zero fill. A[31:5] has no effect on the result.
- R7: With select bit 2 set, the result is B shifted right logically by A[4:0] (0x10 by 2 gives 0x4).
- R8: With select bit 1 set, the result is B shifted right by A[4:0], with the vacated bits filled from B[31].
- R9: With select bit 0 set, the result is B[15:0] in bits 31:16, and bits 15:0 are zero. A has no effect.
- R10: With no select bit set, the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 12 | One-hot operation select (bit 11 add down to bit 0 upper-immediate) |
| src_a | input | 32 | First source; supplies the shift distance for shifts |
| src_b | input | 32 | Second source; the value that is shifted or placed in the upper half |
| result | output | 32 | Combinational result |

## Verification
The bench builds the unit with its default width of 32. At that width the 5-bit shift distance covers every value from 0 to 31, and the sign bit sits at bit 31. The directed vectors therefore reach the following cases:

- full-width shifts, and the all-ones result of an arithmetic shift by 31
- wrap-around of add and subtract at the 32-bit boundary
- signed and unsigned comparisons of operands that differ only in the meaning of bit 31

Randomised operands per operation then cover the general data paths.

// File: rtl/alu_onehot_pkg.sv
package alu_onehot_pkg;
    localparam int NUM_OPS = 12;

    // Bit position of each operation in the one-hot select
    typedef enum int {
        OP_LUI  = 0,
        OP_SRA  = 1,
        OP_SRL  = 2,
        OP_SLL  = 3,
        OP_XOR  = 4,
        OP_OR   = 5,
        OP_NOR  = 6,
        OP_AND  = 7,
        OP_SLTU = 8,
        OP_SLT  = 9,
        OP_SUB  = 10,
        OP_ADD  = 11
    } op_idx_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic             is_sub,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum,
    output logic             lt_signed,
    output logic             lt_unsigned
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic             carry;
        logic             lt_s;
    } addsub_t;

    addsub_t s_d;
    logic [WIDTH-1:0] b_eff;

    always_comb begin
        b_eff = is_sub ? ~b : b;
        {s_d.carry, s_d.sum} = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, is_sub};
        s_d.lt_s = (a[MSB] ^ b[MSB]) ? a[MSB] : s_d.sum[MSB];
    end

    assign sum         = s_d.sum;
    assign lt_signed   = s_d.lt_s;
    assign lt_unsigned = ~s_d.carry;

    always_comb begin
        if (is_sub && (a == b)) begin
            // R4
            eq_cmp_chk: assert (sum == '0 && !lt_unsigned && !lt_signed);
        end
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [SHW-1:0]   amount,
    input  logic [WIDTH-1:0] value,
    output logic [WIDTH-1:0] sll_o,
    output logic [WIDTH-1:0] srl_o,
    output logic [WIDTH-1:0] sra_o
);
    typedef struct packed {
        logic [WIDTH-1:0] l;
        logic [WIDTH-1:0] rl;
        logic [WIDTH-1:0] ra;
    } shift_t;

    shift_t sh_d;

    always_comb begin
        sh_d.l  = value << amount;
        sh_d.rl = value >> amount;
        sh_d.ra = WIDTH'($signed(value) >>> amount);
    end

    assign sll_o = sh_d.l;
    assign srl_o = sh_d.rl;
    assign sra_o = sh_d.ra;

    always_comb begin
        if (!value[WIDTH-1]) begin
            // R8
            sra_pos_chk: assert (sra_o == srl_o);
        end
        if (amount == '0) begin
            // R6
            zero_shift_chk: assert (sll_o == value && srl_o == value);
        end
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] nor_o,
    output logic [WIDTH-1:0] xor_o,
    output logic [WIDTH-1:0] upper_o
);
    localparam int HALF = WIDTH / 2;

    typedef struct packed {
        logic [WIDTH-1:0] a_and;
        logic [WIDTH-1:0] a_or;
        logic [WIDTH-1:0] a_nor;
        logic [WIDTH-1:0] a_xor;
        logic [WIDTH-1:0] up;
    } logic_t;

    logic_t lg_d;

    always_comb begin
        lg_d.a_and = a & b;
        lg_d.a_or  = a | b;
        lg_d.a_nor = ~(a | b);
        lg_d.a_xor = a ^ b;
        lg_d.up    = {b[HALF-1:0], {HALF{1'b0}}};
    end

    assign and_o   = lg_d.a_and;
    assign or_o    = lg_d.a_or;
    assign nor_o   = lg_d.a_nor;
    assign xor_o   = lg_d.a_xor;
    assign upper_o = lg_d.up;

    always_comb begin
        // R5
        bitwise_rel_chk: assert (((and_o | xor_o) == or_o) && ((or_o ^ nor_o) == '1));
    end
endmodule

// File: rtl/alu_onehot.sv
module alu_onehot
    import alu_onehot_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [NUM_OPS-1:0] op_sel,
    input  logic [WIDTH-1:0]   src_a,
    input  logic [WIDTH-1:0]   src_b,
    output logic [WIDTH-1:0]   result
);
    localparam int SHW  = $clog2(WIDTH);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] sum, sll_v, srl_v, sra_v;
    logic [WIDTH-1:0] and_v, or_v, nor_v, xor_v, up_v;
    logic             lt_s, lt_u;
    logic             use_sub;

    assign use_sub = op_sel[OP_SUB] | op_sel[OP_SLT] | op_sel[OP_SLTU];

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .is_sub      (use_sub),
        .a           (src_a),
        .b           (src_b),
        .sum         (sum),
        .lt_signed   (lt_s),
        .lt_unsigned (lt_u)
    );

    alu_shift #(.WIDTH(WIDTH), .SHW(SHW)) u_shift (
        .amount (src_a[SHW-1:0]),
        .value  (src_b),
        .sll_o  (sll_v),
        .srl_o  (srl_v),
        .sra_o  (sra_v)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a       (src_a),
        .b       (src_b),
        .and_o   (and_v),
        .or_o    (or_v),
        .nor_o   (nor_v),
        .xor_o   (xor_v),
        .upper_o (up_v)
    );

    logic [WIDTH-1:0] lane_d [NUM_OPS];
    logic [WIDTH-1:0] result_d;

    always_comb begin
        lane_d[OP_ADD]  = sum;
        lane_d[OP_SUB]  = sum;
        lane_d[OP_SLT]  = {{(WIDTH-1){1'b0}}, lt_s};
        lane_d[OP_SLTU] = {{(WIDTH-1){1'b0}}, lt_u};
        lane_d[OP_AND]  = and_v;
        lane_d[OP_NOR]  = nor_v;
        lane_d[OP_OR]   = or_v;
        lane_d[OP_XOR]  = xor_v;
        lane_d[OP_SLL]  = sll_v;
        lane_d[OP_SRL]  = srl_v;
        lane_d[OP_SRA]  = sra_v;
        lane_d[OP_LUI]  = up_v;
    end

    // AND-OR mux over the one-hot lanes
    always_comb begin
        result_d = '0;
        for (int i = 0; i < NUM_OPS; i++) begin
            result_d |= lane_d[i] & {WIDTH{op_sel[i]}};
        end
    end

    assign result = result_d;

    always_comb begin
        // R10
        sel_onehot_chk: assert ($onehot0(op_sel));
        if (op_sel == '0) begin
            // R10
            idle_zero_chk: assert (result == '0);
        end
        if (op_sel[OP_SLT] || op_sel[OP_SLTU]) begin
            // R3
            slt_bool_chk: assert (result[WIDTH-1:1] == '0);
        end
        if (op_sel[OP_LUI]) begin
            // R9
            lui_low_clear_chk: assert (result[HALF-1:0] == '0);
        end
    end
endmodule

// File: tb/tb_alu_onehot.sv
`timescale 1ns / 1ps
module tb_alu_onehot;
    logic        clk = 1'b0;
    logic [11:0] op_sel = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] result;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    alu_onehot dut (
        .op_sel (op_sel),
        .src_a  (src_a),
        .src_b  (src_b),
        .result (result)
    );

    function automatic logic [31:0] model(int idx, logic [31:0] a, logic [31:0] b);
        int sh;
        sh = int'(a[4:0]);
        case (idx)
            11: return a + b;
            10: return a - b;
            9:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            8:  return (a < b) ? 32'd1 : 32'd0;
            7:  return a & b;
            6:  return ~(a | b);
            5:  return a | b;
            4:  return a ^ b;
            3:  return b << sh;
            2:  return b >> sh;
            1:  return 32'($signed(b) >>> sh);
            0:  return {b[15:0], 16'h0000};
            default: return 32'h0;
        endcase
    endfunction

    // idx < 0 means no select bit
    task automatic run(int idx, logic [31:0] a, logic [31:0] b,
                       logic [31:0] expect_v, string req);
        @(posedge clk);
        #2;
        op_sel = (idx < 0) ? 12'h000 : (12'h001 << idx);
        src_a  = a;
        src_b  = b;
        @(negedge clk);
        n_checks++;
        if (result !== expect_v) begin
            n_errors++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
                     req, idx, a, b, result, expect_v);
        end
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R10: idle select gives zero
        run(-1, 32'hDEADBEEF, 32'h12345678, 32'h0, "R10");
        // R1
        run(11, 32'h1, 32'd19, 32'h14, "R1");
        run(11, 32'hFFFFFFFF, 32'h1, 32'h0, "R1");
        // R2
        run(10, 32'h11, 32'h4, 32'hD, "R2");
        run(10, 32'h0, 32'h1, 32'hFFFFFFFF, "R2");
        // R3
        run(9, 32'hFFFFFFE2, 32'hFFFFFFF3, 32'h1, "R3");
        run(9, 32'h1, 32'hFFFFFFFF, 32'h0, "R3");
        run(9, 32'h80000000, 32'h7FFFFFFF, 32'h1, "R3");
        // R4
        run(8, 32'h1, 32'hFFFFFFFF, 32'h1, "R4");
        run(8, 32'h80000000, 32'h7FFFFFFF, 32'h0, "R4");
        run(8, 32'h5, 32'h5, 32'h0, "R4");
        // R5
        run(6, 32'hD, 32'h10, 32'hFFFFFFE2, "R5");
        run(5, 32'hFFFFFFE2, 32'h11, 32'hFFFFFFF3, "R5");
        run(4, 32'hFFFFFFF3, 32'hFFFFFFE2, 32'h11, "R5");
        run(7, 32'hF0F0FF00, 32'h0FF0F0F0, 32'h00F0F000, "R5");
        // R6: upper bits of A ignored
        run(3, 32'h4, 32'h1, 32'h10, "R6");
        run(3, 32'hFFFFFFE4, 32'h1, 32'h10, "R6");
        run(3, 32'd31, 32'h3, 32'h80000000, "R6");
        // R7
        run(2, 32'h2, 32'h10, 32'h4, "R7");
        run(2, 32'd31, 32'h80000000, 32'h1, "R7");
        // R8
        run(1, 32'd31, 32'h80000000, 32'hFFFFFFFF, "R8");
        run(1, 32'd4, 32'h70000000, 32'h07000000, "R8");
        // R9: A has no effect
        run(0, 32'hFFFFFFFF, 32'hABCD1234, 32'h12340000, "R9");
        run(0, 32'h0, 32'hABCD1234, 32'h12340000, "R9");
        // Randomised sweep of every operation against the model
        for (int op = 0; op < 12; op++) begin
            for (int k = 0; k < 25; k++) begin
                logic [31:0] ra;
                logic [31:0] rb;
                ra = $urandom;
                rb = $urandom;
                case (op)
                    11: run(op, ra, rb, model(op, ra, rb), "R1");
                    10: run(op, ra, rb, model(op, ra, rb), "R2");
                    9:  run(op, ra, rb, model(op, ra, rb), "R3");
                    8:  run(op, ra, rb, model(op, ra, rb), "R4");
                    3:  run(op, ra, rb, model(op, ra, rb), "R6");
                    2:  run(op, ra, rb, model(op, ra, rb), "R7");
                    1:  run(op, ra, rb, model(op, ra, rb), "R8");
                    0:  run(op, ra, rb, model(op, ra, rb), "R9");
                    default: run(op, ra, rb, model(op, ra, rb), "R5");
                endcase
            end
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule